// File: doc/BRIEF.md
# Configurable four-cell logic cluster

The block is a small cluster of four identical logic cells that share one clock, one clock enable and one clear. Each cell evaluates a 4-input lookup table over its own four function inputs. It can replace that result with a full-adder sum fed by a carry chain that runs from cell 0 up to cell 3. Each cell then registers either its function result or its direct data input. The lookup tables of cells 0 and 1 can be fused into one 5-input function, and so can those of cells 2 and 3. The fifth input is the direct data input of the odd cell of the pair. It picks which of the two table results cell 0 or cell 2 presents.

Four bus drivers, enabled together by one line, put the registered cell values onto a shared bus. The cluster is configured through a one-bit serial port. While the load strobe is high, the configuration vector shifts in most significant bit first. During that time every logic output reads 0 and the flip-flops keep their contents.

The function inputs and the direct data inputs make up the cluster's 20 logic inputs. The X, Q and DO outputs of the four cells make up its 12 logic outputs.

Top module: `logic_cluster`

## Requirements
- R1: While rst_ni is low, the 74-bit configuration vector and all four flip-flops are cleared. With a cleared configuration and ci_i low, every output is 0.
- R2: Cell k has a 16-bit table held at configuration bits [18k+15:18k]. When no other mode applies, x_o[k] is the table bit indexed by {F4,F3,F2,F1}, where F1..F4 of cell k are f_i[4k+0]..f_i[4k+3].
- R3: Configuration bit 72 fuses cells 0 and 1, and bit 73 fuses cells 2 and 3. When a pair is fused, the even cell's function becomes the odd cell's table result if di_i of the odd cell is 1, and its own table result otherwise. The odd cell's function is unchanged.
- R4: Configuration bit 18k+17 puts cell k in carry mode. In carry mode x_o[k] = F1^F2^cin and the cell's carry-out is the majority of F1, F2 and cin. Otherwise the carry passes through unchanged. The chain enters cell 0 from ci_i, and co_o is cell 3's carry-out.
- R5: Configuration bit 18k+16 selects the flip-flop data of cell k: when it is 1 the data is di_i[k], and when it is 0 the data is x_o[k]. do_o[k] shows that selected data.
- R6: On a rising clock edge with ce_i high, q_o takes the value do_o had before the edge. With ce_i low, q_o holds.
- R7: clr_i is asynchronous and active high. It drives all four q_o bits to 0 at once, whatever ce_i is, and keeps them at 0 while it stays high.
- R8: While cfg_en_i is high, each rising edge shifts cfg_data_i into bit 0 of the configuration vector and moves every other bit up by one, so the first bit sent ends in bit 73. During loading, x_o, q_o, do_o, co_o, bus_o and bus_oe_o are 0 and the flip-flops do not capture. After loading, q_o shows the values it held before the load.
- R9: bus_oe_o equals bus_en_i while not loading. bus_o equals q_o when bus_oe_o is 1 and is 0 when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared cluster clock |
| rst_ni | input | 1 | Active-low asynchronous reset of configuration and flip-flops |
| clr_i | input | 1 | Active-high asynchronous clear of the four flip-flops |
| ce_i | input | 1 | Shared clock enable |
| cfg_en_i | input | 1 | Configuration load strobe |
| cfg_data_i | input | 1 | Serial configuration bit, MSB first |
| f_i | input | 16 | Function inputs, four per cell (cell k at [4k+3:4k]) |
| di_i | input | 4 | Direct data input per cell |
| ci_i | input | 1 | Carry into cell 0 |
| bus_en_i | input | 1 | Common enable of the four bus drivers |
| x_o | output | 4 | Combinational output per cell |
| q_o | output | 4 | Registered output per cell |
| do_o | output | 4 | Flip-flop data per cell |
| co_o | output | 1 | Carry out of cell 3 |
| bus_o | output | 4 | Bus driver values |
| bus_oe_o | output | 1 | Bus drive enable |

## Verification
Several properties are checked on every cycle. Loading keeps the outputs quiet and shifts the configuration one bit per edge. An enabled edge moves do_o into q_o, a disabled edge holds q_o, an active clear keeps q_o at zero, and an idle bus stays low. The table decode, the pair fusing, the carry ripple and the choice of flip-flop data depend on the loaded configuration. Only the bench scenarios can show those, because they compare the outputs for several configurations and input patterns against a model computed in the bench. The scenarios also cover a clear raised between clock edges and the restoration of q_o after a load.

// File: rtl/cluster_pkg.sv
package cluster_pkg;
  localparam int N_CELLS    = 4;
  localparam int LUT_K      = 4;
  localparam int LUT_BITS   = 1 << LUT_K;
  localparam int CELL_CFG_W = LUT_BITS + 2;
  localparam int N_PAIRS    = N_CELLS / 2;
  localparam int CFG_W      = N_CELLS * CELL_CFG_W + N_PAIRS;
  localparam int DSEL_OFS   = LUT_BITS;
  localparam int CARRY_OFS  = LUT_BITS + 1;
  localparam int MERGE_OFS  = N_CELLS * CELL_CFG_W;
endpackage

// File: rtl/cfg_shift.sv
module cfg_shift #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         d_i,
  output logic [W-1:0] cfg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_o <= '0;
    else if (en_i) cfg_o <= {cfg_o[W-2:0], d_i};
  end
endmodule

// File: rtl/cell_lut.sv
module cell_lut #(
  parameter int K = 4,
  localparam int N = 1 << K
) (
  input  logic [N-1:0] bits_i,
  input  logic [K-1:0] sel_i,
  output logic         y_o
);
  assign y_o = bits_i[sel_i];
endmodule

// File: rtl/pair_merge.sv
module pair_merge (
  input  logic lo_i,
  input  logic hi_i,
  input  logic sel_i,
  input  logic en_i,
  output logic y_o
);
  assign y_o = (en_i && sel_i) ? hi_i : lo_i;
endmodule

// File: rtl/cell_core.sv
module cell_core (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic ce_i,
  input  logic hold_i,
  input  logic fn_i,
  input  logic f1_i,
  input  logic f2_i,
  input  logic di_i,
  input  logic cin_i,
  input  logic carry_en_i,
  input  logic dsel_i,
  output logic x_o,
  output logic d_o,
  output logic cout_o,
  output logic q_o
);
  logic sum;
  logic maj;

  assign sum    = f1_i ^ f2_i ^ cin_i;
  assign maj    = (f1_i & f2_i) | (f1_i & cin_i) | (f2_i & cin_i);
  assign x_o    = carry_en_i ? sum : fn_i;
  assign cout_o = carry_en_i ? maj : cin_i;
  assign d_o    = dsel_i ? di_i : x_o;

  always_ff @(posedge clk_i or negedge rst_ni or posedge clr_i) begin
    if (!rst_ni)               q_o <= 1'b0;
    else if (clr_i)            q_o <= 1'b0;
    else if (ce_i && !hold_i)  q_o <= d_o;
  end
endmodule

// File: rtl/logic_cluster.sv
module logic_cluster
  import cluster_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 ce_i,
  input  logic                 cfg_en_i,
  input  logic                 cfg_data_i,
  input  logic [N_CELLS*LUT_K-1:0] f_i,
  input  logic [N_CELLS-1:0]   di_i,
  input  logic                 ci_i,
  input  logic                 bus_en_i,
  output logic [N_CELLS-1:0]   x_o,
  output logic [N_CELLS-1:0]   q_o,
  output logic [N_CELLS-1:0]   do_o,
  output logic                 co_o,
  output logic [N_CELLS-1:0]   bus_o,
  output logic                 bus_oe_o
);
  logic [CFG_W-1:0]   cfg_q;
  logic [N_CELLS-1:0] lut_y;
  logic [N_CELLS-1:0] fn;
  logic [N_CELLS-1:0] x_int;
  logic [N_CELLS-1:0] d_int;
  logic [N_CELLS-1:0] q_int;
  logic [N_CELLS:0]   cy;

  cfg_shift #(.W(CFG_W)) u_cfg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (cfg_en_i),
    .d_i   (cfg_data_i),
    .cfg_o (cfg_q)
  );

  assign cy[0] = ci_i;

  for (genvar k = 0; k < N_CELLS; k++) begin : g_cell
    localparam int BASE = k * CELL_CFG_W;

    cell_lut #(.K(LUT_K)) u_lut (
      .bits_i(cfg_q[BASE +: LUT_BITS]),
      .sel_i (f_i[k*LUT_K +: LUT_K]),
      .y_o   (lut_y[k])
    );

    cell_core u_core (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (clr_i),
      .ce_i      (ce_i),
      .hold_i    (cfg_en_i),
      .fn_i      (fn[k]),
      .f1_i      (f_i[k*LUT_K]),
      .f2_i      (f_i[k*LUT_K+1]),
      .di_i      (di_i[k]),
      .cin_i     (cy[k]),
      .carry_en_i(cfg_q[BASE+CARRY_OFS]),
      .dsel_i    (cfg_q[BASE+DSEL_OFS]),
      .x_o       (x_int[k]),
      .d_o       (d_int[k]),
      .cout_o    (cy[k+1]),
      .q_o       (q_int[k])
    );
  end

  for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
    pair_merge u_merge (
      .lo_i (lut_y[2*p]),
      .hi_i (lut_y[2*p+1]),
      .sel_i(di_i[2*p+1]),
      .en_i (cfg_q[MERGE_OFS+p]),
      .y_o  (fn[2*p])
    );
    assign fn[2*p+1] = lut_y[2*p+1];
  end

  // outputs stay quiet while configuration is shifting
  assign x_o      = cfg_en_i ? '0 : x_int;
  assign do_o     = cfg_en_i ? '0 : d_int;
  assign q_o      = cfg_en_i ? '0 : q_int;
  assign co_o     = cfg_en_i ? 1'b0 : cy[N_CELLS];
  assign bus_oe_o = bus_en_i & ~cfg_en_i;
  assign bus_o    = bus_oe_o ? q_int : '0;
endmodule

// File: rtl/cluster_chk.sv
module cluster_chk
  import cluster_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               clr_i,
  input logic               ce_i,
  input logic               cfg_en_i,
  input logic               cfg_data_i,
  input logic               bus_en_i,
  input logic [N_CELLS-1:0] x_o,
  input logic [N_CELLS-1:0] q_o,
  input logic [N_CELLS-1:0] do_o,
  input logic               co_o,
  input logic [N_CELLS-1:0] bus_o,
  input logic               bus_oe_o,
  input logic [CFG_W-1:0]   cfg_q
);
  AST_LOAD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i |-> (x_o == '0 && q_o == '0 && do_o == '0 && !co_o && bus_o == '0 && !bus_oe_o)); // R8
  AST_LOAD_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i |=> (cfg_q[0] == $past(cfg_data_i) && cfg_q[CFG_W-1:1] == $past(cfg_q[CFG_W-2:0]))); // R8
  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> q_o == '0); // R7
  AST_CE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_i && !cfg_en_i) |=> (clr_i || cfg_en_i || q_o == $past(q_o))); // R6
  AST_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && !clr_i && !cfg_en_i) |=> (clr_i || cfg_en_i || q_o == $past(do_o))); // R6
  AST_BUS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_en_i |-> (bus_o == '0 && !bus_oe_o)); // R9
endmodule

bind logic_cluster cluster_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clr_i     (clr_i),
  .ce_i      (ce_i),
  .cfg_en_i  (cfg_en_i),
  .cfg_data_i(cfg_data_i),
  .bus_en_i  (bus_en_i),
  .x_o       (x_o),
  .q_o       (q_o),
  .do_o      (do_o),
  .co_o      (co_o),
  .bus_o     (bus_o),
  .bus_oe_o  (bus_oe_o),
  .cfg_q     (cfg_q)
);

// File: tb/sim_logic_cluster.sv
`timescale 1ns/1ps
module sim_logic_cluster;
  localparam int CW = 74;
  localparam int NV = 8;
  // {f[15:0], di[3:0], ci}
  localparam logic [20:0] STIM [NV] = '{
    {16'h0000, 4'h0, 1'b0},
    {16'hFFFF, 4'hF, 1'b1},
    {16'h000F, 4'hA, 1'b0},
    {16'h3210, 4'h5, 1'b1},
    {16'hC30F, 4'h2, 1'b0},
    {16'h6A6F, 4'h8, 1'b1},
    {16'h0F0F, 4'h0, 1'b1},
    {16'h3300, 4'hF, 1'b0}
  };
  localparam logic [CW-1:0] CFG_A = {2'b00, 1'b1, 1'b1, 16'h0000, 1'b1, 1'b0, 16'h1234,
                                     1'b0, 1'b1, 16'hFFFE, 1'b0, 1'b0, 16'h8000};
  localparam logic [CW-1:0] CFG_B = {2'b11, 1'b0, 1'b0, 16'h6996, 1'b0, 1'b1, 16'hF0F0,
                                     1'b0, 1'b0, 16'hCCCC, 1'b0, 1'b0, 16'hAAAA};

  logic clk = 1'b0;
  logic rst_ni = 1'b0, clr_i = 1'b0, ce_i = 1'b0, cfg_en_i = 1'b0, cfg_data_i = 1'b0;
  logic [15:0] f_i = '0;
  logic [3:0] di_i = '0;
  logic ci_i = 1'b0, bus_en_i = 1'b0;
  logic [3:0] x_o, q_o, do_o, bus_o;
  logic co_o, bus_oe_o;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  logic_cluster u0 (
    .clk_i(clk), .rst_ni(rst_ni), .clr_i(clr_i), .ce_i(ce_i),
    .cfg_en_i(cfg_en_i), .cfg_data_i(cfg_data_i), .f_i(f_i), .di_i(di_i),
    .ci_i(ci_i), .bus_en_i(bus_en_i), .x_o(x_o), .q_o(q_o), .do_o(do_o),
    .co_o(co_o), .bus_o(bus_o), .bus_oe_o(bus_oe_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic model(input logic [CW-1:0] c, input logic [15:0] f, input logic [3:0] di,
                       input logic ci, output logic [3:0] x, output logic co, output logic [3:0] d);
    logic [3:0] lut, fn;
    logic cin;
    for (int k = 0; k < 4; k++) lut[k] = c[k*18 + int'(f[k*4 +: 4])];
    fn = lut;
    if (c[72]) fn[0] = di[1] ? lut[1] : lut[0];
    if (c[73]) fn[2] = di[3] ? lut[3] : lut[2];
    cin = ci;
    for (int k = 0; k < 4; k++) begin
      if (c[k*18+17]) begin
        x[k] = f[4*k] ^ f[4*k+1] ^ cin;
        cin  = (f[4*k] & f[4*k+1]) | (f[4*k] & cin) | (f[4*k+1] & cin);
      end else begin
        x[k] = fn[k];
      end
      d[k] = c[k*18+16] ? di[k] : x[k];
    end
    co = cin;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic load(input logic [CW-1:0] c);
    cfg_en_i = 1'b1;
    for (int i = CW-1; i >= 0; i--) begin
      cfg_data_i = c[i];
      step();
      if (i == 37) begin
        chk("R8 quiet x/do/q", {4'h0, x_o, do_o, q_o}, 16'h0);
        chk("R8 quiet co/bus", {11'h0, co_o, bus_o}, 16'h0);
      end
    end
    cfg_en_i = 1'b0;
    cfg_data_i = 1'b0;
    #1;
  endtask

  task automatic run_table(input logic [CW-1:0] c, input string req);
    logic [3:0] ex, ed;
    logic eco;
    for (int v = 0; v < NV; v++) begin
      {f_i, di_i, ci_i} = STIM[v];
      ce_i = 1'b1;
      #2;
      model(c, f_i, di_i, ci_i, ex, eco, ed);
      chk({req, " x"}, {12'h0, x_o}, {12'h0, ex});
      chk("R4 co", {15'h0, co_o}, {15'h0, eco});
      chk("R5 do", {12'h0, do_o}, {12'h0, ed});
      step();
      chk("R6 capture", {12'h0, q_o}, {12'h0, ed});
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] qprev, ex, ed;
    logic eco;
    f_i = 16'hFFFF; di_i = 4'hF;
    #10;
    chk("R1 reset x/q/do", {4'h0, x_o, q_o, do_o}, 16'h0);
    chk("R1 reset co/bus", {11'h0, co_o, bus_o}, 16'h0);
    step(); rst_ni = 1'b1; step();

    load(CFG_A);
    run_table(CFG_A, "R2");
    load(CFG_B);
    run_table(CFG_B, "R3");

    // R6: hold with ce low
    f_i = 16'h0000; di_i = 4'hF; ci_i = 1'b0; ce_i = 1'b1;
    step();
    qprev = q_o;
    chk("R6 q set", {12'h0, q_o}, 16'h0004);
    ce_i = 1'b0; di_i = 4'h0; f_i = 16'hFFFF;
    step(); step();
    chk("R6 hold", {12'h0, q_o}, {12'h0, qprev});

    // R9: bus drivers
    bus_en_i = 1'b0; #1;
    chk("R9 bus off", {11'h0, bus_oe_o, bus_o}, 16'h0);
    bus_en_i = 1'b1; #1;
    chk("R9 bus on", {11'h0, bus_oe_o, bus_o}, {11'h0, 1'b1, qprev});

    // R8: load hides q and does not capture
    ce_i = 1'b1; di_i = 4'h0; f_i = 16'h0000;
    load(CFG_B);
    chk("R8 q kept", {12'h0, q_o}, {12'h0, qprev});
    ce_i = 1'b0;

    // R7: asynchronous clear between edges, ce high
    ce_i = 1'b1; di_i = 4'hF;
    #1; clr_i = 1'b1; #1;
    chk("R7 async clr", {12'h0, q_o}, 16'h0);
    step();
    chk("R7 clr held", {12'h0, q_o}, 16'h0);
    #1; clr_i = 1'b0;
    step();
    chk("R7 after clr", {12'h0, q_o}, 16'h0004);
    ce_i = 1'b0;

    // R8: loaded vector takes effect (CFG_A after B)
    load(CFG_A);
    {f_i, di_i, ci_i} = STIM[5]; #2;
    model(CFG_A, f_i, di_i, ci_i, ex, eco, ed);
    chk("R8 new cfg", {11'h0, eco, x_o}, {11'h0, co_o, ex});
    chk("R8 new cfg x", {12'h0, x_o}, {12'h0, ex});

    // R1: reset mid run
    f_i = 16'hFFFF; di_i = 4'hF; ci_i = 1'b0;
    rst_ni = 1'b0; #1;
    chk("R1 mid reset q", {12'h0, q_o}, 16'h0);
    chk("R1 mid reset x/co", {11'h0, co_o, x_o}, 16'h0);
    step(); rst_ni = 1'b1; step();

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule